// File: doc/BRIEF.md
# Tape Command Sequencer

This block sits on the host side of a parallel link to a nine-track tape formatter. A local client hands it a command as a set of flags. The block then asserts the matching qualifier lines, waits a setup window, and drives a timed start pulse. After that it follows the formatter's busy handshake until the command finishes. The block also produces the rewind and rewind-with-unload pulses, and it can abort a data command by dropping the formatter-enable line for a fixed time.

All lines to and from the formatter are active low, as open-collector wiring needs. Every drive input passes through a two-stage synchronizer before the control logic sees it. Every minimum pulse width and setup time is a parameter counted in clock cycles. The block refuses a command and reports an error code in three cases: the drive is not ready, the command is a write to a protected tape, or formatter-busy never arrives.

Top module: `tape_cmd_seq`

## Requirements
- R1: After reset, `goN`, `rewN`, `rwuN` and all six qualifier outputs are high, `fenN` is low, `cmdReady` is 1, and `cmdDone` and `errValid` are 0.
- R2: The block refuses a command, rewind or unload while the synchronized ready input is deasserted. It then pulses `errValid` with `errCode` = 1 in the cycle after the request and drives no pulse.
- R3: The block refuses a command with the write flag (`cmdFlags[0]`) while file-protect is asserted. It then pulses `errValid` with `errCode` = 2 and drives no pulse.
- R4: `cmdFlags` bits are [0] write, [1] filemark, [2] erase, [3] reverse, [4] high-speed, [5] edit. They drive, low, `wrtN`, `wfmN`, `eraseN`, `revN`, `hispN` and `editN`. The filemark and erase outputs are asserted only when write is also set.
- R5: Qualifiers appear in the cycle after acceptance. `goN` falls QSET_CYC+1 cycles after acceptance, or HISP_CYC+1 cycles when high-speed is set.
- R6: `goN` stays low for exactly GO_CYC cycles, and the qualifier outputs do not change while it is low.
- R7: After the start pulse, `cmdDone` pulses once for one cycle. It comes when data-busy, having been seen asserted, deasserts, or when formatter-busy drops. `cmdReady` then returns to 1.
- R8: The qualifier outputs stay asserted until the synchronized formatter-busy is deasserted with the block idle. They are released after that.
- R9: If formatter-busy is not seen within TMO_CYC cycles after the start pulse, `errValid` pulses with `errCode` = 3 and the block returns to idle.
- R10: A rewind request drives `rewN` low, and an unload request drives `rwuN` low, for exactly REW_CYC cycles, followed by one `cmdDone`. At most one of `goN`, `rewN` and `rwuN` is low at a time.
- R11: An abort request, while idle or while waiting on busy, drives `fenN` high for exactly FEN_CYC cycles, then low again, with no `cmdDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Command request strobe |
| cmdFlags | input | 6 | Command flags (see R4) |
| rewReq | input | 1 | Rewind request |
| unloadReq | input | 1 | Rewind-with-unload request |
| abortReq | input | 1 | Abort request |
| cmdReady | output | 1 | Idle, accepting requests |
| cmdDone | output | 1 | Command completed pulse |
| errValid | output | 1 | Error pulse |
| errCode | output | 2 | 1 not ready, 2 protected, 3 busy timeout |
| fbyN | input | 1 | Formatter busy from drive, active low |
| dbyN | input | 1 | Data busy from drive, active low |
| rdyN | input | 1 | Drive ready, active low |
| fptN | input | 1 | File protect, active low |
| goN | output | 1 | Start pulse, active low |
| wrtN | output | 1 | Write qualifier |
| wfmN | output | 1 | Filemark qualifier |
| eraseN | output | 1 | Erase qualifier |
| revN | output | 1 | Reverse qualifier |
| hispN | output | 1 | High-speed qualifier |
| editN | output | 1 | Edit qualifier |
| rewN | output | 1 | Rewind pulse |
| rwuN | output | 1 | Rewind-and-unload pulse |
| fenN | output | 1 | Formatter enable, active low |

## Verification
The bench counts sample indices on falling edges, with index 0 being the first sample after the edge that accepts a request. Refusals and qualifiers are due at index 0. The start pulse falls at index setup+1 and lasts exactly GO_CYC samples. The busy timeout is due at index QSET_CYC+GO_CYC+TMO_CYC. The enable drop starts one sample after the abort edge. The drive model in the bench changes busy lines only on falling edges. The two-cycle synchronizer delay is then fixed, so each check samples at a single computed index, or counts over a window that holds the whole pulse.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int QUAL_W = 6;
  localparam int F_WRT = 0;
  localparam int F_WFM = 1;
  localparam int F_ERASE = 2;
  localparam int F_REV = 3;
  localparam int F_HISP = 4;
  localparam int F_EDIT = 5;

  localparam int NIN = 4;
  localparam int IN_FBY = 0;
  localparam int IN_DBY = 1;
  localparam int IN_RDY = 2;
  localparam int IN_FPT = 3;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_NOTRDY = 2'd1;
  localparam logic [1:0] ERR_PROT = 2'd2;
  localparam logic [1:0] ERR_TMO = 2'd3;

  typedef enum logic [2:0] {
    IDLE, SETUP, GO_PULSE, WAIT_FBY_RISE, WAIT_DBY_CLEAR, DONE, ABORT, REW_PULSE
  } seqState_t;

  typedef enum logic [2:0] {
    T_QSET, T_HISP, T_GO, T_REW, T_FEN, T_TMO
  } tmrSel_t;

  typedef struct packed {
    logic    loadQual;
    logic    clearQual;
    logic    goOn;
    logic    rewOn;
    logic    rwuOn;
    logic    fenOff;
    logic    tmrLoad;
    tmrSel_t tmrSel;
  } ctrlStb_t;
endpackage

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMR_W = 16,
  parameter int unsigned QSET_CYC = 10,
  parameter int unsigned HISP_CYC = 100,
  parameter int unsigned GO_CYC = 100,
  parameter int unsigned REW_CYC = 100,
  parameter int unsigned FEN_CYC = 200,
  parameter int unsigned TMO_CYC = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [QUAL_W-1:0] cmdFlags,
  input  logic [NIN-1:0]    rawInN,
  output logic [NIN-1:0]    inAct,
  output logic              tmrDone,
  output logic [QUAL_W-1:0] qualN,
  output logic              goN,
  output logic              rewN,
  output logic              rwuN,
  output logic              fenN
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);
  localparam logic [TMR_W-1:0] SAT = {TMR_W{1'b1}};

  // two-stage (or deeper) synchronizers, inputs turned active high
  for (genvar i = 0; i < NIN; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawInN[i]};
    end
    assign inAct[i] = ~chain[SYNC_STAGES-1];
  end

  function automatic logic [TMR_W-1:0] tmrLen(input tmrSel_t s);
    case (s)
      T_QSET:  return TMR_W'(QSET_CYC);
      T_HISP:  return TMR_W'(HISP_CYC);
      T_GO:    return TMR_W'(GO_CYC);
      T_REW:   return TMR_W'(REW_CYC);
      T_FEN:   return TMR_W'(FEN_CYC);
      T_TMO:   return TMR_W'(TMO_CYC);
      default: return ONE;
    endcase
  endfunction

  // single shared window counter
  logic [TMR_W-1:0] tmrCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              tmrCnt <= '0;
    else if (stb.tmrLoad)   tmrCnt <= tmrLen(stb.tmrSel) - ONE;
    else if (tmrCnt != '0)  tmrCnt <= tmrCnt - ONE;
  end
  assign tmrDone = (tmrCnt == '0);

  // qualifier register, R4 masking: filemark/erase only with write
  logic [QUAL_W-1:0] qualR, qualMasked;
  always_comb begin
    qualMasked = cmdFlags;
    if (!cmdFlags[F_WRT]) begin
      qualMasked[F_WFM]   = 1'b0;
      qualMasked[F_ERASE] = 1'b0;
    end
  end
  always_ff @(posedge clk) begin
    if (!rstN)              qualR <= '0;
    else if (stb.loadQual)  qualR <= qualMasked;
    else if (stb.clearQual) qualR <= '0;
  end
  assign qualN = ~qualR;

  // registered pulse outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      goN <= 1'b1; rewN <= 1'b1; rwuN <= 1'b1; fenN <= 1'b0;
    end else begin
      goN  <= ~stb.goOn;
      rewN <= ~stb.rewOn;
      rwuN <= ~stb.rwuOn;
      fenN <= stb.fenOff;
    end
  end

  // run-length counters watched by the assertions below
  logic [TMR_W-1:0] goRun, hispRun, fenRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      goRun <= '0; hispRun <= '0; fenRun <= '0;
    end else begin
      goRun   <= goN ? '0 : (goRun == SAT ? SAT : goRun + ONE);
      hispRun <= qualN[F_HISP] ? '0 : (hispRun == SAT ? SAT : hispRun + ONE);
      fenRun  <= !fenN ? '0 : (fenRun == SAT ? SAT : fenRun + ONE);
    end
  end

  a_r6_go_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goN) |-> goRun == TMR_W'(GO_CYC));
  a_r6_qual_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!goN && $past(!goN)) |-> $stable(qualN));
  a_r5_hisp_setup: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(goN) && !qualN[F_HISP]) |-> hispRun >= TMR_W'(HISP_CYC));
  a_r11_fen_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fenN) |-> fenRun == TMR_W'(FEN_CYC));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~goN, ~rewN, ~rwuN}) <= 1);
  a_r4_mark_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (!qualN[F_WFM] || !qualN[F_ERASE]) |-> !qualN[F_WRT]);
endmodule

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic       cmdHisp,
  input  logic       rewReq,
  input  logic       unloadReq,
  input  logic       abortReq,
  input  logic       fbyS,
  input  logic       dbyS,
  input  logic       rdyS,
  input  logic       fptS,
  input  logic       tmrDone,
  output ctrlStb_t   stb,
  output logic       cmdReady,
  output logic       cmdDone,
  output logic       errValid,
  output logic [1:0] errCode
);
  seqState_t state, nxt;
  logic dbySeen, isUnload, errSet;
  logic [1:0] errNext;

  always_comb begin
    stb = '0;
    nxt = state;
    errSet = 1'b0;
    errNext = ERR_NONE;
    case (state)
      IDLE: begin
        if (abortReq) begin
          nxt = ABORT; stb.tmrLoad = 1'b1; stb.tmrSel = T_FEN;
        end else if (rewReq || unloadReq) begin
          if (!rdyS) begin
            errSet = 1'b1; errNext = ERR_NOTRDY;
          end else begin
            nxt = REW_PULSE; stb.tmrLoad = 1'b1; stb.tmrSel = T_REW;
          end
        end else if (cmdValid) begin
          if (!rdyS) begin
            errSet = 1'b1; errNext = ERR_NOTRDY;
          end else if (cmdWrite && fptS) begin
            errSet = 1'b1; errNext = ERR_PROT;
          end else begin
            nxt = SETUP; stb.loadQual = 1'b1; stb.tmrLoad = 1'b1;
            stb.tmrSel = cmdHisp ? T_HISP : T_QSET;
          end
        end else if (!fbyS) begin
          stb.clearQual = 1'b1;
        end
      end
      SETUP: if (tmrDone) begin
        nxt = GO_PULSE; stb.tmrLoad = 1'b1; stb.tmrSel = T_GO;
      end
      GO_PULSE: begin
        stb.goOn = 1'b1;
        if (tmrDone) begin
          nxt = WAIT_FBY_RISE; stb.tmrLoad = 1'b1; stb.tmrSel = T_TMO;
        end
      end
      WAIT_FBY_RISE: begin
        if (abortReq) begin
          nxt = ABORT; stb.tmrLoad = 1'b1; stb.tmrSel = T_FEN;
        end else if (fbyS) begin
          nxt = WAIT_DBY_CLEAR;
        end else if (tmrDone) begin
          nxt = IDLE; errSet = 1'b1; errNext = ERR_TMO;
        end
      end
      WAIT_DBY_CLEAR: begin
        if (abortReq) begin
          nxt = ABORT; stb.tmrLoad = 1'b1; stb.tmrSel = T_FEN;
        end else if ((dbySeen && !dbyS) || !fbyS) begin
          nxt = DONE;
        end
      end
      DONE: nxt = IDLE;
      ABORT: begin
        stb.fenOff = 1'b1;
        if (tmrDone) nxt = IDLE;
      end
      REW_PULSE: begin
        stb.rewOn = !isUnload;
        stb.rwuOn = isUnload;
        if (tmrDone) nxt = DONE;
      end
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE; dbySeen <= 1'b0; isUnload <= 1'b0;
      errValid <= 1'b0; errCode <= ERR_NONE;
    end else begin
      state <= nxt;
      errValid <= errSet;
      if (errSet) errCode <= errNext;
      if (stb.loadQual) dbySeen <= 1'b0;
      else if (state == WAIT_DBY_CLEAR && dbyS) dbySeen <= 1'b1;
      if (state == IDLE && !abortReq && (rewReq || unloadReq)) isUnload <= unloadReq;
    end
  end

  assign cmdReady = (state == IDLE);
  assign cmdDone  = (state == DONE);

  a_r2_unready_refused: assert property (@(posedge clk) disable iff (!rstN)
    (state == IDLE && !abortReq && (cmdValid || rewReq || unloadReq) && !rdyS)
      |=> (errValid && errCode == ERR_NOTRDY && state == IDLE));
  a_r3_protect_refused: assert property (@(posedge clk) disable iff (!rstN)
    (state == IDLE && !abortReq && !rewReq && !unloadReq && cmdValid && rdyS && cmdWrite && fptS)
      |=> (errValid && errCode == ERR_PROT && state == IDLE));
  a_r9_timeout_source: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errCode == ERR_TMO) |-> $past(state) == WAIT_FBY_RISE);
  a_r7_done_source: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> ($past(state) == WAIT_DBY_CLEAR || $past(state) == REW_PULSE));
endmodule

// File: rtl/tape_cmd_seq.sv
module tape_cmd_seq
  import tcs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMR_W = 16,
  parameter int unsigned QSET_CYC = 10,
  parameter int unsigned HISP_CYC = 100,
  parameter int unsigned GO_CYC = 100,
  parameter int unsigned REW_CYC = 100,
  parameter int unsigned FEN_CYC = 200,
  parameter int unsigned TMO_CYC = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [5:0] cmdFlags,
  input  logic       rewReq,
  input  logic       unloadReq,
  input  logic       abortReq,
  output logic       cmdReady,
  output logic       cmdDone,
  output logic       errValid,
  output logic [1:0] errCode,
  input  logic       fbyN,
  input  logic       dbyN,
  input  logic       rdyN,
  input  logic       fptN,
  output logic       goN,
  output logic       wrtN,
  output logic       wfmN,
  output logic       eraseN,
  output logic       revN,
  output logic       hispN,
  output logic       editN,
  output logic       rewN,
  output logic       rwuN,
  output logic       fenN
);
  ctrlStb_t stb;
  logic [NIN-1:0] inAct;
  logic [QUAL_W-1:0] qualN;
  logic tmrDone;

  tcs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .cmdWrite(cmdFlags[F_WRT]), .cmdHisp(cmdFlags[F_HISP]),
    .rewReq(rewReq), .unloadReq(unloadReq), .abortReq(abortReq),
    .fbyS(inAct[IN_FBY]), .dbyS(inAct[IN_DBY]), .rdyS(inAct[IN_RDY]), .fptS(inAct[IN_FPT]),
    .tmrDone(tmrDone), .stb(stb), .cmdReady(cmdReady), .cmdDone(cmdDone),
    .errValid(errValid), .errCode(errCode)
  );

  tcs_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .TMR_W(TMR_W), .QSET_CYC(QSET_CYC), .HISP_CYC(HISP_CYC),
    .GO_CYC(GO_CYC), .REW_CYC(REW_CYC), .FEN_CYC(FEN_CYC), .TMO_CYC(TMO_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdFlags(cmdFlags),
    .rawInN({fptN, rdyN, dbyN, fbyN}), .inAct(inAct), .tmrDone(tmrDone),
    .qualN(qualN), .goN(goN), .rewN(rewN), .rwuN(rwuN), .fenN(fenN)
  );

  assign wrtN   = qualN[F_WRT];
  assign wfmN   = qualN[F_WFM];
  assign eraseN = qualN[F_ERASE];
  assign revN   = qualN[F_REV];
  assign hispN  = qualN[F_HISP];
  assign editN  = qualN[F_EDIT];
endmodule

// File: tb/tape_cmd_seq_tb_top.sv
module tape_cmd_seq_tb_top;
  localparam int QSET = 3;
  localparam int HISP = 8;
  localparam int GOC = 5;
  localparam int REWC = 6;
  localparam int FENC = 7;
  localparam int TMO = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cmdValid, rewReq, unloadReq, abortReq;
  logic [5:0] cmdFlags;
  logic cmdReady, cmdDone, errValid;
  logic [1:0] errCode;
  logic fbyN, dbyN, rdyN, fptN;
  logic goN, wrtN, wfmN, eraseN, revN, hispN, editN, rewN, rwuN, fenN;

  tape_cmd_seq #(.QSET_CYC(QSET), .HISP_CYC(HISP), .GO_CYC(GOC), .REW_CYC(REWC),
                 .FEN_CYC(FENC), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdFlags(cmdFlags),
    .rewReq(rewReq), .unloadReq(unloadReq), .abortReq(abortReq),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .errValid(errValid), .errCode(errCode),
    .fbyN(fbyN), .dbyN(dbyN), .rdyN(rdyN), .fptN(fptN),
    .goN(goN), .wrtN(wrtN), .wfmN(wfmN), .eraseN(eraseN), .revN(revN),
    .hispN(hispN), .editN(editN), .rewN(rewN), .rwuN(rwuN), .fenN(fenN)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] expQual(input logic [5:0] f);
    logic [5:0] e = f;
    if (!f[0]) e[2:1] = 2'b00;
    return e;
  endfunction

  function automatic logic [5:0] qualAct();
    return ~{editN, hispN, revN, eraseN, wfmN, wrtN};
  endfunction

  // drive model: responds to the end of the start pulse
  bit modelEn = 0, holdFby = 0, skipDby = 0;
  int fbyDelay = 2, dbyLen = 3;
  int mPhase = 0, mCnt = 0;
  logic prevGo = 1'b1;
  always @(negedge clk) begin
    if (!rstN) begin
      mPhase = 0; fbyN = 1'b1; dbyN = 1'b1; prevGo = 1'b1;
    end else begin
      case (mPhase)
        0: if (modelEn && goN && !prevGo) begin mPhase = 1; mCnt = fbyDelay; end
        1: if (mCnt <= 1) begin fbyN = 1'b0; mPhase = 2; mCnt = 3; end else mCnt--;
        2: if (mCnt <= 1) begin
             if (skipDby) begin mPhase = 4; mCnt = 2; end
             else begin dbyN = 1'b0; mPhase = 3; mCnt = dbyLen; end
           end else mCnt--;
        3: if (mCnt <= 1) begin dbyN = 1'b1; mPhase = 4; mCnt = 10; end else mCnt--;
        4: if (mCnt <= 1) begin
             if (!holdFby) begin fbyN = 1'b1; mPhase = 0; end
           end else mCnt--;
        default: mPhase = 0;
      endcase
      prevGo = goN;
    end
  end

  task automatic setLevels(input bit rdy, input bit fpt);
    rdyN = ~rdy; fptN = ~fpt;
    repeat (4) @(negedge clk);
  endtask

  task automatic runCmd(input logic [5:0] f, input bit rdy, input bit fpt);
    int expErr, goFirst, goLen, doneCnt;
    logic [5:0] eq, doneQual;
    bit qualBad;
    setLevels(rdy, fpt);
    expErr = !rdy ? 1 : ((f[0] && fpt) ? 2 : 0);
    eq = expQual(f);
    modelEn = 1;
    @(negedge clk); cmdValid = 1'b1; cmdFlags = f;
    @(negedge clk); cmdValid = 1'b0;
    if (expErr != 0) begin
      chk(errValid == 1'b1 && int'(errCode) == expErr, expErr == 1 ? "R2 refusal code" : "R3 refusal code",
          int'(errCode), expErr);
      goLen = 0;
      for (int i = 0; i < 12; i++) begin
        if (!goN) goLen++;
        @(negedge clk);
      end
      chk(goLen == 0 && qualAct() == 6'd0, expErr == 1 ? "R2 no pulse" : "R3 no pulse", goLen, 0);
      return;
    end
    chk(errValid == 1'b0, "R2 R3 accepted without error", int'(errValid), 0);
    chk(qualAct() == eq, "R4 qualifier lines", int'(qualAct()), int'(eq));
    goFirst = -1; goLen = 0; doneCnt = 0; qualBad = 0; doneQual = '0;
    for (int idx = 0; idx < 400; idx++) begin
      if (!goN) begin
        if (goFirst < 0) goFirst = idx;
        goLen++;
        if (qualAct() != eq) qualBad = 1;
      end
      if (cmdDone) begin
        doneCnt++;
        doneQual = qualAct();
        @(negedge clk);
        if (cmdDone) doneCnt++;
        break;
      end
      @(negedge clk);
    end
    chk(goFirst == (f[4] ? HISP : QSET) + 1, "R5 start pulse setup", goFirst, (f[4] ? HISP : QSET) + 1);
    chk(goLen == GOC, "R6 start pulse width", goLen, GOC);
    chk(!qualBad, "R6 qualifiers stable during start", int'(qualBad), 0);
    chk(doneCnt == 1, "R7 single done pulse", doneCnt, 1);
    chk(doneQual == eq, "R8 qualifiers held at done", int'(doneQual), int'(eq));
    while (fbyN == 1'b0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(qualAct() == 6'd0 && cmdReady, "R8 R7 release after busy drops", int'(qualAct()), 0);
  endtask

  task automatic runPulse(input bit unload, input bit rdy);
    int rewLen, rwuLen, doneCnt;
    setLevels(rdy, 1'b0);
    @(negedge clk);
    if (unload) unloadReq = 1'b1; else rewReq = 1'b1;
    @(negedge clk); unloadReq = 1'b0; rewReq = 1'b0;
    if (!rdy) chk(errValid && errCode == 2'd1, "R2 rewind refused", int'(errCode), 1);
    rewLen = 0; rwuLen = 0; doneCnt = 0;
    for (int i = 0; i < 30; i++) begin
      if (!rewN) rewLen++;
      if (!rwuN) rwuLen++;
      if (cmdDone) doneCnt++;
      @(negedge clk);
    end
    chk(rewLen == (rdy && !unload ? REWC : 0), "R10 rewind width", rewLen, rdy && !unload ? REWC : 0);
    chk(rwuLen == (rdy && unload ? REWC : 0), "R10 unload width", rwuLen, rdy && unload ? REWC : 0);
    chk(doneCnt == (rdy ? 1 : 0), "R10 pulse done", doneCnt, rdy ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'h0000_5eed));
    rstN = 1'b0; cmdValid = 1'b0; cmdFlags = '0; rewReq = 1'b0; unloadReq = 1'b0;
    abortReq = 1'b0; rdyN = 1'b1; fptN = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(goN && rewN && rwuN && qualAct() == 6'd0, "R1 pulse and qualifier lines idle", int'(qualAct()), 0);
    chk(!fenN && cmdReady && !cmdDone && !errValid, "R1 enable and status", int'(fenN), 0);

    // directed: plain read, high-speed, write+mark+erase, mark/erase without write
    fbyDelay = 2; dbyLen = 3; skipDby = 0;
    runCmd(6'b000000, 1, 0);
    runCmd(6'b010000, 1, 0);
    runCmd(6'b000111, 1, 0);
    runCmd(6'b100110, 1, 0);
    skipDby = 1;
    runCmd(6'b001000, 1, 0);
    skipDby = 0;
    // refusals
    runCmd(6'b000001, 0, 0);
    runCmd(6'b000011, 1, 1);
    runCmd(6'b000010, 1, 1);

    // R9 busy timeout
    setLevels(1, 0);
    modelEn = 0;
    begin
      int seen;
      seen = -1;
      @(negedge clk); cmdValid = 1'b1; cmdFlags = 6'b000000;
      @(negedge clk); cmdValid = 1'b0;
      for (int idx = 0; idx < 60; idx++) begin
        if (errValid && seen < 0) seen = idx;
        @(negedge clk);
      end
      chk(seen == QSET + GOC + TMO, "R9 timeout cycle", seen, QSET + GOC + TMO);
      chk(errCode == 2'd3 && cmdReady && qualAct() == 6'd0, "R9 timeout code and idle", int'(errCode), 3);
    end

    // R11 abort while data busy
    modelEn = 1; holdFby = 1; dbyLen = 30;
    begin
      int fenLen, doneCnt;
      @(negedge clk); cmdValid = 1'b1; cmdFlags = 6'b000001;
      @(negedge clk); cmdValid = 1'b0;
      while (fbyN) @(negedge clk);
      repeat (4) @(negedge clk);
      abortReq = 1'b1;
      @(negedge clk); abortReq = 1'b0;
      fenLen = 0; doneCnt = 0;
      for (int i = 0; i < 30; i++) begin
        if (fenN) fenLen++;
        if (cmdDone) doneCnt++;
        @(negedge clk);
      end
      chk(fenLen == FENC, "R11 enable drop width", fenLen, FENC);
      chk(doneCnt == 0 && !fenN && cmdReady, "R11 no done after abort", doneCnt, 0);
      holdFby = 0; dbyLen = 3;
      while (!fbyN) @(negedge clk);
      repeat (5) @(negedge clk);
      // abort while idle
      abortReq = 1'b1;
      @(negedge clk); abortReq = 1'b0;
      fenLen = 0;
      for (int i = 0; i < 20; i++) begin
        if (fenN) fenLen++;
        @(negedge clk);
      end
      chk(fenLen == FENC, "R11 idle abort width", fenLen, FENC);
    end

    // R10 rewind and unload
    runPulse(0, 1);
    runPulse(1, 1);
    runPulse(0, 0);

    // constrained random commands
    for (int k = 0; k < 40; k++) begin
      logic [5:0] f;
      bit rdy, fpt;
      f = 6'($urandom);
      rdy = ($urandom % 5) != 0;
      fpt = ($urandom % 4) == 0;
      fbyDelay = 1 + int'($urandom % 5);
      dbyLen = 1 + int'($urandom % 6);
      skipDby = ($urandom % 4) == 0;
      runCmd(f, rdy, fpt);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  int wdCnt = 0;
  always @(posedge clk) begin
    wdCnt++;
    if (wdCnt > 150000 && !finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wdCnt, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule